// File: doc/BRIEF.md
# Page Write Buffer and Address Pointer

This block sits between the bit-level front-end of a two-wire serial memory slave and a 2048 x 8 storage array. It keeps the 11-bit internal byte pointer and a 16-byte staging buffer. The front-end hands it one event per cycle: a start, a stop, a received device address (3 block-select bits plus the read/write flag), a received write byte, or a request for the next read byte. From these events the block runs byte and page writes, current-address reads, random reads (a write that only loads the pointer, then a repeated start with the read flag set) and sequential reads.

Write data is staged and handed to the array as one commit request when the stop arrives: the page number, a 16-bit byte-valid mask and 128 bits of data. Reads go straight to the array through a one-cycle synchronous read port. While writing, the pointer steps only inside the current 16-byte page. While reading, it steps across the whole array. Programming time and bus bit handling belong to other blocks.

Top module: `pagebuf_top`

## Requirements
- R1: After a synchronous active-low reset, `ptr_out` is 0, `cm_valid` is 0 and `rd_valid` is 0.
- R2: In a write transfer, the first write byte after the device address loads the pointer with {dev_blk[2:0], byte}. dev_blk forms pointer bits 10:8.
- R3: Each further write byte is staged at buffer offset `ptr_out[3:0]`. Then `ptr_out[3:0]` increments modulo 16 and `ptr_out[10:4]` stays unchanged.
- R4: A stop after at least one staged byte gives `cm_valid` high for exactly the one cycle after the stop. In that cycle `cm_page` = `ptr_out[10:4]`, `cm_mask` bit i is set only if offset i was staged, and `cm_data[8i+7:8i]` holds the last byte staged at offset i.
- R5: When more than 16 bytes are sent, later bytes replace earlier ones at the same offset. When fewer are sent, only the offsets received have mask bits set.
- R6: A read request in read state drives `mem_re` with `mem_raddr` = `ptr_out` in the same cycle. One cycle later `rd_valid` is high and `rd_data` shows the array output. The pointer advances by one over all 11 bits, so 0x7FF is followed by 0x000.
- R7: A stop that follows the word-address byte with no data bytes raises no commit, and the pointer keeps the loaded value.
- R8: A current-address read uses the pointer as the last transfer left it. The block-select bits of a read device address are ignored. After a write ending at offset n, the read returns offset n+1 of the same page, wrapping to offset 0.
- R9: A random read (write address, word byte, repeated start, read address, request) returns the byte at the address just loaded.
- R10: A start that arrives before the stop discards the staged bytes, so the later stop raises no commit and the array is not changed.
- R11: A write byte outside write states, and a read request outside read state, change neither the pointer nor the buffer, and produce no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| ev_dev | input | 1 | Device address byte received |
| dev_blk | input | 3 | Block-select bits of the device address |
| dev_rd | input | 1 | Read flag of the device address (1 = read) |
| ev_wbyte | input | 1 | Byte received from the master |
| wbyte | input | 8 | Received byte |
| ev_rreq | input | 1 | Front-end requests the next read byte |
| mem_rdata | input | 8 | Array read data, one cycle after `mem_re` |
| mem_re | output | 1 | Array read enable |
| mem_raddr | output | 11 | Array read address |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| rd_data | output | 8 | Byte to shift out |
| cm_valid | output | 1 | Commit request, one cycle |
| cm_page | output | 7 | Page number of the commit |
| cm_mask | output | 16 | Byte-valid mask of the commit |
| cm_data | output | 128 | Page data, offset i in bits 8i+7:8i |
| ptr_out | output | 11 | Current byte pointer |

## Verification
The assertions check properties that must hold on every cycle. A commit lasts one cycle, follows a stop and carries a non-empty mask. A read-valid follows each array read by exactly one cycle. Each read step moves the full pointer by one, and each staged write byte moves only the low four pointer bits while the page bits hold. What ends up in memory can only be shown by the bench's scenarios against its reference model: overwrite after more than 16 bytes, the partial mask, a dummy write that loads without committing, a start that discards staged bytes, and read-back after page wrap and array rollover.

// File: rtl/pagebuf_pkg.sv
// Shared types for the page write buffer.
// Assumes: one front-end event per cycle at most.
package pagebuf_pkg;

    // Transfer phase of the controller
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a device address
        ST_WADDR = 2'd1,   // write address taken, word byte next
        ST_WDATA = 2'd2,   // staging data bytes
        ST_READ  = 2'd3    // serving read requests
    } pb_state_t;

    // Pointer update selection
    typedef enum logic [1:0] {
        PTR_HOLD = 2'd0,
        PTR_LOAD = 2'd1,
        PTR_PAGE = 2'd2,   // step low bits only, wrap in page
        PTR_FULL = 2'd3    // step all bits, wrap at top of array
    } ptr_op_t;

endpackage

// File: rtl/pagebuf_ptr.sv
// Byte pointer register. It loads, steps inside a page, or steps across the array.
// Assumes: op is decoded by the controller with one action per cycle.
module pagebuf_ptr
    import pagebuf_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ptr_op_t           op,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [PAGE_W-1:0] ONE_P = PAGE_W'(1);
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

    // Pointer update per selected operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            case (op)
                PTR_LOAD: ptr <= load_val;
                PTR_PAGE: ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + ONE_P};
                PTR_FULL: ptr <= ptr + ONE_A;
                default:  ptr <= ptr;
            endcase
        end
    end
endmodule

// File: rtl/pagebuf_store.sv
// Page staging buffer: one data byte and one valid flag per page offset.
// Assumes: clr and wr are never both high; clr wins if they are.
module pagebuf_store #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        wr,
    input  logic [PAGE_W-1:0]           idx,
    input  logic [DATA_W-1:0]           wdata,
    output logic [(1<<PAGE_W)-1:0]      mask,
    output logic [(1<<PAGE_W)*DATA_W-1:0] data
);
    localparam int NB = 1 << PAGE_W;

    for (genvar g = 0; g < NB; g++) begin : g_slot
        logic [DATA_W-1:0] byte_q;
        logic              vld_q;

        // Capture a byte at its offset; drop validity on clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
                vld_q  <= 1'b0;
            end else if (clr) begin
                vld_q  <= 1'b0;
            end else if (wr && (idx == PAGE_W'(g))) begin
                byte_q <= wdata;
                vld_q  <= 1'b1;
            end
        end

        assign mask[g] = vld_q;
        assign data[g*DATA_W +: DATA_W] = byte_q;
    end
endmodule

// File: rtl/pagebuf_ctrl.sv
// Transfer controller. It turns front-end events into pointer, buffer,
// commit and read actions.
// Assumes: events are mutually exclusive; if not, start > stop > dev > byte > read.
module pagebuf_ctrl
    import pagebuf_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    localparam int BLK_W = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_dev,
    input  logic [BLK_W-1:0]  dev_blk,
    input  logic              dev_rd,
    input  logic              ev_wbyte,
    input  logic [DATA_W-1:0] wbyte,
    input  logic              ev_rreq,
    input  logic              buf_any,
    output pb_state_t         st,
    output ptr_op_t           ptr_op,
    output logic [ADDR_W-1:0] load_val,
    output logic              buf_wr,
    output logic              buf_clr,
    output logic              commit,
    output logic              mem_re
);
    pb_state_t        st_nx;
    logic [BLK_W-1:0] blk_q;

    // State and latched block-select bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            blk_q <= '0;
        end else begin
            st <= st_nx;
            if (ev_dev && !ev_start && !ev_stop) blk_q <= dev_blk;
        end
    end

    assign load_val = {blk_q, wbyte};

    // Event decode into next state and datapath actions
    always_comb begin
        st_nx   = st;
        ptr_op  = PTR_HOLD;
        buf_wr  = 1'b0;
        buf_clr = 1'b0;
        commit  = 1'b0;
        mem_re  = 1'b0;
        if (ev_start) begin
            st_nx   = ST_IDLE;
            buf_clr = 1'b1;
        end else if (ev_stop) begin
            commit  = (st == ST_WDATA) && buf_any;
            buf_clr = 1'b1;
            st_nx   = ST_IDLE;
        end else if (ev_dev) begin
            st_nx = dev_rd ? ST_READ : ST_WADDR;
        end else if (ev_wbyte) begin
            if (st == ST_WADDR) begin
                ptr_op = PTR_LOAD;
                st_nx  = ST_WDATA;
            end else if (st == ST_WDATA) begin
                buf_wr = 1'b1;
                ptr_op = PTR_PAGE;
            end
        end else if (ev_rreq && (st == ST_READ)) begin
            mem_re = 1'b1;
            ptr_op = PTR_FULL;
        end
    end
endmodule

// File: rtl/pagebuf_top.sv
// Page write buffer and address pointer for a paged byte array.
// It stages write bytes, issues one commit per write on stop, and
// serves reads through a one-cycle synchronous read port.
// Assumes: the array returns mem_rdata one cycle after mem_re.
module pagebuf_top
    import pagebuf_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8,
    localparam int BLK_W  = ADDR_W - DATA_W,
    localparam int NB     = 1 << PAGE_W,
    localparam int PGN_W  = ADDR_W - PAGE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_start,
    input  logic                 ev_stop,
    input  logic                 ev_dev,
    input  logic [BLK_W-1:0]     dev_blk,
    input  logic                 dev_rd,
    input  logic                 ev_wbyte,
    input  logic [DATA_W-1:0]    wbyte,
    input  logic                 ev_rreq,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 mem_re,
    output logic [ADDR_W-1:0]    mem_raddr,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 cm_valid,
    output logic [PGN_W-1:0]     cm_page,
    output logic [NB-1:0]        cm_mask,
    output logic [NB*DATA_W-1:0] cm_data,
    output logic [ADDR_W-1:0]    ptr_out
);
    pb_state_t            st;
    ptr_op_t              ptr_op;
    logic [ADDR_W-1:0]    load_val;
    logic                 buf_wr, buf_clr, commit;
    logic [NB-1:0]        buf_mask;
    logic [NB*DATA_W-1:0] buf_data;

    pagebuf_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_dev(ev_dev),
        .dev_blk(dev_blk), .dev_rd(dev_rd),
        .ev_wbyte(ev_wbyte), .wbyte(wbyte), .ev_rreq(ev_rreq),
        .buf_any(|buf_mask),
        .st(st), .ptr_op(ptr_op), .load_val(load_val),
        .buf_wr(buf_wr), .buf_clr(buf_clr), .commit(commit), .mem_re(mem_re)
    );

    pagebuf_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .op(ptr_op), .load_val(load_val), .ptr(ptr_out)
    );

    pagebuf_store #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr(buf_wr),
        .idx(ptr_out[PAGE_W-1:0]), .wdata(wbyte),
        .mask(buf_mask), .data(buf_data)
    );

    assign mem_raddr = ptr_out;
    assign rd_data   = mem_rdata;

    // Commit request register, captured before the buffer clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cm_valid <= 1'b0;
            cm_page  <= '0;
            cm_mask  <= '0;
            cm_data  <= '0;
        end else begin
            cm_valid <= commit;
            if (commit) begin
                cm_page <= ptr_out[ADDR_W-1:PAGE_W];
                cm_mask <= buf_mask;
                cm_data <= buf_data;
            end
        end
    end

    // Read-valid follows the array read by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= mem_re;
    end
endmodule

// File: rtl/pagebuf_chk.sv
// Property checker for pagebuf_top, attached by bind.
// Assumes: the same clock and synchronous active-low reset as the design.
module pagebuf_chk
    import pagebuf_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4,
    localparam int NB = 1 << PAGE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_start,
    input logic              ev_stop,
    input logic              ev_wbyte,
    input pb_state_t         st,
    input logic [ADDR_W-1:0] ptr_out,
    input logic              mem_re,
    input logic              rd_valid,
    input logic              cm_valid,
    input logic [NB-1:0]     cm_mask
);
    // R4: commit lasts a single cycle
    p_commit_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |=> !cm_valid);

    // R4: commit always carries at least one byte
    p_commit_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |-> (cm_mask != '0));

    // R10: commit only right after a stop
    p_commit_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |-> $past(ev_stop));

    // R6: read valid follows each array read
    p_rd_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> rd_valid);

    // R6: no read valid without an array read
    p_rd_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_re |=> !rd_valid);

    // R6: read steps the full pointer by one
    p_read_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (ptr_out == ADDR_W'($past(ptr_out) + ADDR_W'(1))));

    // R3: a staged byte steps only the in-page bits
    p_page_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WDATA && ev_wbyte && !ev_start && !ev_stop) |=>
        ((ptr_out[ADDR_W-1:PAGE_W] == $past(ptr_out[ADDR_W-1:PAGE_W])) &&
         (ptr_out[PAGE_W-1:0] == PAGE_W'($past(ptr_out[PAGE_W-1:0]) + PAGE_W'(1)))));
endmodule

bind pagebuf_top pagebuf_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_wbyte(ev_wbyte), .st(st), .ptr_out(ptr_out), .mem_re(mem_re),
    .rd_valid(rd_valid), .cm_valid(cm_valid), .cm_mask(cm_mask)
);

// File: tb/tb_pagebuf_top.sv
module tb_pagebuf_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ev_start = 0, ev_stop = 0, ev_dev = 0, dev_rd = 0;
    logic [2:0]   dev_blk = 0;
    logic         ev_wbyte = 0, ev_rreq = 0;
    logic [7:0]   wbyte = 0;
    logic [7:0]   mem_rdata;
    logic         mem_re, rd_valid, cm_valid;
    logic [10:0]  mem_raddr, ptr_out;
    logic [7:0]   rd_data;
    logic [6:0]   cm_page;
    logic [15:0]  cm_mask;
    logic [127:0] cm_data;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;   // 50 MHz

    pagebuf_top dut (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_dev(ev_dev), .dev_blk(dev_blk), .dev_rd(dev_rd),
        .ev_wbyte(ev_wbyte), .wbyte(wbyte), .ev_rreq(ev_rreq),
        .mem_rdata(mem_rdata), .mem_re(mem_re), .mem_raddr(mem_raddr),
        .rd_valid(rd_valid), .rd_data(rd_data), .cm_valid(cm_valid),
        .cm_page(cm_page), .cm_mask(cm_mask), .cm_data(cm_data), .ptr_out(ptr_out)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    // Array model: synchronous read, masked page write on commit
    logic [7:0] ram [0:2047];
    initial for (int i = 0; i < 2048; i++) ram[i] = pat(i);
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= ram[mem_raddr];
        if (cm_valid)
            for (int i = 0; i < 16; i++)
                if (cm_mask[i]) ram[cm_page * 16 + i] <= cm_data[i*8 +: 8];
    end

    // Behavioural reference model
    int         r_st, r_ptr, r_blk;
    bit         r_mask [16];
    logic [7:0] r_buf  [16];
    bit         x_cm, x_rd;
    int         x_page;
    logic [15:0] x_mask;
    logic [7:0] x_data [16];
    logic [7:0] x_rdata;

    always @(posedge clk) begin
        x_cm = 0;
        x_rd = 0;
        if (!rst_n) begin
            r_st = 0; r_ptr = 0; r_blk = 0;
            foreach (r_mask[i]) r_mask[i] = 0;
        end else if (ev_start) begin
            r_st = 0;
            foreach (r_mask[i]) r_mask[i] = 0;
        end else if (ev_stop) begin
            x_mask = '0;
            foreach (r_mask[i]) x_mask[i] = r_mask[i];
            if (r_st == 2 && x_mask != 0) begin
                x_cm = 1;
                x_page = r_ptr / 16;
                foreach (r_buf[i]) x_data[i] = r_buf[i];
            end
            foreach (r_mask[i]) r_mask[i] = 0;
            r_st = 0;
        end else if (ev_dev) begin
            r_blk = int'(dev_blk);
            r_st = dev_rd ? 3 : 1;
        end else if (ev_wbyte) begin
            if (r_st == 1) begin
                r_ptr = r_blk * 256 + int'(wbyte);
                r_st = 2;
            end else if (r_st == 2) begin
                r_buf[r_ptr % 16]  = wbyte;
                r_mask[r_ptr % 16] = 1;
                r_ptr = (r_ptr / 16) * 16 + (r_ptr + 1) % 16;
            end
        end else if (ev_rreq && r_st == 3) begin
            x_rd = 1;
            x_rdata = ram[r_ptr];
            r_ptr = (r_ptr + 1) % 2048;
        end
    end

    // Per-cycle comparison, away from the clock edge
    always @(posedge clk) begin
        #8;
        if (rst_n && !done) begin
            bit bad;
            bad = 0;
            tests++;
            if (ptr_out !== 11'(r_ptr)) bad = 1;
            if (cm_valid !== x_cm || rd_valid !== x_rd) bad = 1;
            if (x_rd && rd_data !== x_rdata) bad = 1;
            if (x_cm) begin
                if (cm_page !== 7'(x_page) || cm_mask !== x_mask) bad = 1;
                for (int i = 0; i < 16; i++)
                    if (x_mask[i] && cm_data[i*8 +: 8] !== x_data[i]) bad = 1;
            end
            if (bad) begin
                fails++;
                $display("FAIL %s model: ptr %0h/%0h cm %0b/%0b rd %0b/%0b rdata %0h/%0h mask %0h/%0h",
                         cur_req, ptr_out, r_ptr, cm_valid, x_cm, rd_valid, x_rd,
                         rd_data, x_rdata, cm_mask, x_mask);
            end
        end
    end

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); ev_start = 1; @(negedge clk); ev_start = 0;
    endtask
    task automatic do_stop();
        @(negedge clk); ev_stop = 1; @(negedge clk); ev_stop = 0;
    endtask
    task automatic do_dev(logic [2:0] b, logic rd);
        @(negedge clk); ev_dev = 1; dev_blk = b; dev_rd = rd;
        @(negedge clk); ev_dev = 0;
    endtask
    task automatic do_byte(logic [7:0] v);
        @(negedge clk); ev_wbyte = 1; wbyte = v; @(negedge clk); ev_wbyte = 0;
    endtask
    task automatic do_rreq();
        @(negedge clk); ev_rreq = 1; @(negedge clk); ev_rreq = 0;
    endtask
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        cur_req = "R1";
        chk("R1 ptr", 128'(ptr_out), 128'(0));
        chk("R1 cm_valid", 128'(cm_valid), 128'(0));
        chk("R1 rd_valid", 128'(rd_valid), 128'(0));

        // R2 R4: byte write at 0x53A
        cur_req = "R2";
        do_start(); do_dev(3'd5, 0); do_byte(8'h3A);
        chk("R2 ptr load", 128'(ptr_out), 128'(11'h53A));
        cur_req = "R4";
        do_byte(8'hC4); do_stop();
        chk("R4 cm_valid", 128'(cm_valid), 128'(1));
        chk("R4 cm_page", 128'(cm_page), 128'(7'h53));
        chk("R4 cm_mask", 128'(cm_mask), 128'(16'h0400));
        chk("R4 cm_data", 128'(cm_data[87:80]), 128'(8'hC4));
        idle(3);

        // R8: current-address read, block bits ignored
        cur_req = "R8";
        do_start(); do_dev(3'd6, 1); do_rreq();
        chk("R8 rd_valid", 128'(rd_valid), 128'(1));
        chk("R8 next after write", 128'(rd_data), 128'(pat(11'h53B)));
        chk("R6 ptr step", 128'(ptr_out), 128'(11'h53C));
        do_stop(); idle(2);

        // R3 R5: 18-byte page write from 0x0FE wraps in page
        cur_req = "R5";
        do_start(); do_dev(3'd0, 0); do_byte(8'hFE);
        for (int k = 0; k < 18; k++) do_byte(8'(8'h40 + k));
        chk("R3 ptr page wrap", 128'(ptr_out), 128'(11'h0F0));
        do_stop();
        chk("R5 full mask", 128'(cm_mask), 128'(16'hFFFF));
        chk("R5 overwrite off14", 128'(cm_data[119:112]), 128'(8'h50));
        chk("R5 off0", 128'(cm_data[7:0]), 128'(8'h42));
        chk("R4 page", 128'(cm_page), 128'(7'h0F));
        idle(3);
        cur_req = "R8";
        do_start(); do_dev(3'd0, 1); do_rreq();
        chk("R8 wrap in page read", 128'(rd_data), 128'(8'h42));
        do_stop(); idle(2);

        // R5: partial write of three bytes
        cur_req = "R5";
        do_start(); do_dev(3'd2, 0); do_byte(8'h10);
        do_byte(8'hA1); do_byte(8'hA2); do_byte(8'hA3); do_stop();
        chk("R5 partial mask", 128'(cm_mask), 128'(16'h0007));
        chk("R5 partial page", 128'(cm_page), 128'(7'h21));
        idle(3);

        // R7 R6: dummy write to 0x7FF, then sequential read across top
        cur_req = "R7";
        do_start(); do_dev(3'd7, 0); do_byte(8'hFF); do_stop();
        chk("R7 no commit", 128'(cm_valid), 128'(0));
        chk("R7 ptr kept", 128'(ptr_out), 128'(11'h7FF));
        cur_req = "R6";
        do_start(); do_dev(3'd3, 1);
        do_rreq(); chk("R6 read 7FF", 128'(rd_data), 128'(pat(2047)));
        do_rreq(); chk("R6 rollover 000", 128'(rd_data), 128'(pat(0)));
        do_rreq(); chk("R6 read 001", 128'(rd_data), 128'(pat(1)));
        chk("R6 ptr", 128'(ptr_out), 128'(11'h002));
        do_stop(); idle(2);

        // R9: random reads
        cur_req = "R9";
        do_start(); do_dev(3'd1, 0); do_byte(8'h20);
        do_start(); do_dev(3'd4, 1); do_rreq();
        chk("R9 random 120", 128'(rd_data), 128'(pat(11'h120)));
        do_stop();
        do_start(); do_dev(3'd5, 0); do_byte(8'h3A);
        do_start(); do_dev(3'd0, 1); do_rreq();
        chk("R9 readback 53A", 128'(rd_data), 128'(8'hC4));
        do_stop(); idle(2);

        // R10: repeated start discards staged bytes
        cur_req = "R10";
        do_start(); do_dev(3'd6, 0); do_byte(8'h00);
        do_byte(8'h11); do_byte(8'h22); do_start(); do_stop();
        chk("R10 no commit", 128'(cm_valid), 128'(0));
        idle(3);
        do_start(); do_dev(3'd6, 0); do_byte(8'h00);
        do_start(); do_dev(3'd0, 1); do_rreq();
        chk("R10 array unchanged", 128'(rd_data), 128'(pat(11'h600)));
        do_stop(); idle(2);

        // R11: stray byte in read state and stray read in idle
        cur_req = "R11";
        do_start(); do_dev(3'd0, 1);
        do_byte(8'h99);
        chk("R11 ptr after stray byte", 128'(ptr_out), 128'(11'h601));
        do_stop();
        do_rreq();
        chk("R11 no read in idle", 128'(rd_valid), 128'(0));
        chk("R11 ptr after stray read", 128'(ptr_out), 128'(11'h601));
        do_start(); do_dev(3'd0, 0); do_byte(8'h05); do_byte(8'h77); do_stop();
        chk("R11 single staged byte", 128'(cm_mask), 128'(16'h0020));
        idle(4);

        finish_run();
    end
endmodule